// File: doc/BRIEF.md
# Load Diagnostic Sequencer

This block decides when the load checks of a bridge-tied audio output stage run, and it keeps the fault indication and the protective shutdown in step with their results. Five detection flags come from analog comparators that are modelled elsewhere: output shorted to a rail, the two outputs shorted together, open load, over-current and over-temperature. The block returns an amplifier enable, an active-low fault pin that stays latched, a busy flag and a power-up hold.

After reset a complete check runs without being asked. It settles, then tests for a rail short, then an output-to-output short, then an open load, and the amplifier is held off throughout. Control fields written while this check runs are held back until it ends. Later runs are requested by the diagnostic enable field. In single mode each rising edge starts one run. In repeat mode the block waits a set period after each run and then starts the next. Any fault shuts the amplifier down. A mask decides only whether the fault pin shows it. A rising edge on the clear field releases both the shutdown and the pin.

Top module: `load_diag_seq`

## Requirements
- R1: After reset the block holds `pwrup_hold_o` high and `amp_en_o` low. It settles for STEP_CYC cycles and then runs the rail, output-short and open tests for STEP_CYC cycles each. It does this whatever the enable field holds. It then drops the hold and raises `amp_en_o`.
- R2: Control and mask inputs seen during the power-up check have no effect until the check ends. From the cycle after it ends, the block uses their current values, so an enable already at 1 counts as a rising edge and starts a run.
- R3: If `diag_clr_i` is 1 during the power-up check, the check is aborted at once and the hold is dropped.
- R4: With `diag_cont_i`=0, a 0-to-1 change of the applied enable field starts exactly one run. Leaving the enable field high starts no further run. An edge that arrives while a run is in progress is ignored.
- R5: With `diag_cont_i`=1 and enable high, each run is followed by a wait of PERIOD_CYC cycles and then by a new run. Clearing either field during the wait returns the block to idle.
- R6: A fault that is not masked makes `amp_en_o` low and `fault_no` low one cycle after the fault is seen. Both stay that way after the flag goes away.
- R7: A 0-to-1 change of the applied clear field sets `fault_no` high again and restores `amp_en_o`.
- R8: The mask bits are: bit 0 output-to-output short, bit 1 open load, bit 2 rail short, bit 3 over-current, bit 4 over-temperature. A masked fault leaves `fault_no` high but still takes `amp_en_o` low.
- R9: The rail, output-short and open flags count only during their own test step. At any other time they have no effect.
- R10: The over-current and over-temperature flags take effect in every state, whether or not a run is in progress.
- R11: `diag_busy_o` is high exactly during the three test steps, for 3*STEP_CYC cycles per run.
- R12: A repeating sequence stops when a fault is detected or when the clear field rises, and it does not resume without a new enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| diag_en_i | input | 1 | Diagnostic enable field (edge-triggered) |
| diag_cont_i | input | 1 | 1 = repeating runs, 0 = single run |
| diag_clr_i | input | 1 | Fault clear field; also aborts power-up check |
| ignore_mask_i | input | 5 | Per-test fault-pin mask (see R8) |
| rail_short_i | input | 1 | Output-to-rail short comparator |
| out_short_i | input | 1 | Output-to-output short comparator |
| open_load_i | input | 1 | Open-load comparator |
| over_cur_i | input | 1 | Over-current comparator |
| over_temp_i | input | 1 | Over-temperature comparator |
| amp_en_o | output | 1 | Amplifier output stage enable |
| fault_no | output | 1 | Latched fault indication, active low |
| diag_busy_o | output | 1 | A test step is in progress |
| pwrup_hold_o | output | 1 | Power-up check in progress |

## Verification
A wrong sequencer state shows up at `diag_busy_o` within one cycle, because the busy window moves or its length changes. A lost or extra shutdown shows up at `amp_en_o` in the cycle after the comparator flag. A mask bit in the wrong position shows up as `fault_no` disagreeing with the expected value while `amp_en_o` is still low. Config applied too early or too late during power-up shows up as a run starting a cycle early or late, or not starting at all, once the hold drops.

// File: rtl/diag_pkg.sv
package diag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD_PUP,
    ST_TEST_RAIL,
    ST_TEST_SHORT,
    ST_TEST_OPEN,
    ST_WAIT_PERIOD,
    ST_FAULTED
  } diag_state_e;

  localparam int NUM_TESTS = 5;
  localparam int IDX_SHORT = 0;
  localparam int IDX_OPEN  = 1;
  localparam int IDX_RAIL  = 2;
  localparam int IDX_OCP   = 3;
  localparam int IDX_OTP   = 4;
endpackage

// File: rtl/diag_cfg_sync.sv
module diag_cfg_sync
  import diag_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 freeze_i,
  input  logic                 en_i,
  input  logic                 cont_i,
  input  logic                 clr_i,
  input  logic [NUM_TESTS-1:0] mask_i,
  output logic                 en_o,
  output logic                 cont_o,
  output logic [NUM_TESTS-1:0] mask_o,
  output logic                 en_rise_o,
  output logic                 clr_rise_o
);
  logic en_q, cont_q, clr_q, en_d, clr_d;
  logic [NUM_TESTS-1:0] mask_q;

  // fields written during the power-up check wait here until it ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cont_q <= 1'b0;
      clr_q  <= 1'b0;
      mask_q <= '0;
      en_d   <= 1'b0;
      clr_d  <= 1'b0;
    end else begin
      en_d  <= en_q;
      clr_d <= clr_q;
      if (!freeze_i) begin
        en_q   <= en_i;
        cont_q <= cont_i;
        clr_q  <= clr_i;
        mask_q <= mask_i;
      end
    end
  end

  assign en_o       = en_q;
  assign cont_o     = cont_q;
  assign mask_o     = mask_q;
  assign en_rise_o  = en_q & ~en_d;
  assign clr_rise_o = clr_q & ~clr_d;

  a_r2_frozen_during_pup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(en_q) && $stable(mask_q));
endmodule

// File: rtl/diag_fsm.sv
module diag_fsm
  import diag_pkg::*;
#(
  parameter int STEP_CYC   = 2000,
  parameter int PERIOD_CYC = 60000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        cont_i,
  input  logic        en_rise_i,
  input  logic        clr_rise_i,
  input  logic        abort_i,
  input  logic        trip_ev_i,
  output diag_state_e state_o,
  output logic        pup_o,
  output logic        busy_o
);
  localparam int MAX_CYC = (STEP_CYC > PERIOD_CYC) ? STEP_CYC : PERIOD_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] STEP_LAST   = CW'(STEP_CYC - 1);
  localparam logic [CW-1:0] PERIOD_LAST = CW'(PERIOD_CYC - 1);

  diag_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic pup_q, pup_d;
  logic step_done, timed;

  assign step_done = (cnt_q == STEP_LAST);
  assign timed = (state_q == ST_HOLD_PUP) || (state_q == ST_TEST_RAIL) ||
                 (state_q == ST_TEST_SHORT) || (state_q == ST_TEST_OPEN) ||
                 (state_q == ST_WAIT_PERIOD);

  always_comb begin
    state_d = state_q;
    pup_d   = pup_q;
    if (trip_ev_i) begin
      state_d = ST_FAULTED;
      pup_d   = 1'b0;
    end else if (pup_q && abort_i) begin
      state_d = ST_IDLE;
      pup_d   = 1'b0;
    end else if (clr_rise_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:       if (en_rise_i) state_d = ST_TEST_RAIL;
        ST_HOLD_PUP:   if (step_done) state_d = ST_TEST_RAIL;
        ST_TEST_RAIL:  if (step_done) state_d = ST_TEST_SHORT;
        ST_TEST_SHORT: if (step_done) state_d = ST_TEST_OPEN;
        ST_TEST_OPEN: begin
          if (step_done) begin
            if (pup_q) begin
              state_d = ST_IDLE;
              pup_d   = 1'b0;
            end else if (cont_i && en_i) begin
              state_d = ST_WAIT_PERIOD;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_WAIT_PERIOD: begin
          if (!cont_i || !en_i)        state_d = ST_IDLE;
          else if (cnt_q == PERIOD_LAST) state_d = ST_TEST_RAIL;
        end
        ST_FAULTED: state_d = ST_FAULTED;
        default:    state_d = ST_IDLE;
      endcase
    end
    if (state_d != state_q) cnt_d = '0;
    else if (timed)         cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD_PUP;
      cnt_q   <= '0;
      pup_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pup_q   <= pup_d;
    end
  end

  assign state_o = state_q;
  assign pup_o   = pup_q;
  assign busy_o  = (state_q == ST_TEST_RAIL) || (state_q == ST_TEST_SHORT) ||
                   (state_q == ST_TEST_OPEN);

  a_r1_pup_never_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pup_q |=> !pup_q);
  a_r5_wait_leaves_without_cont: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_PERIOD) && !cont_i |=> state_q != ST_WAIT_PERIOD);
  a_r3_abort_ends_pup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pup_q && abort_i |=> !pup_q);
endmodule

// File: rtl/diag_fault_latch.sv
module diag_fault_latch
  import diag_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  diag_state_e          state_i,
  input  logic                 rail_i,
  input  logic                 short_i,
  input  logic                 open_i,
  input  logic                 ocp_i,
  input  logic                 otp_i,
  input  logic [NUM_TESTS-1:0] mask_i,
  input  logic                 clr_rise_i,
  output logic                 ev_any_o,
  output logic                 trip_o,
  output logic                 flag_o
);
  logic [NUM_TESTS-1:0] ev;
  logic trip_q, flag_q, shown;

  // load tests count only inside their own window; protection always counts
  assign ev[IDX_SHORT] = (state_i == ST_TEST_SHORT) & short_i;
  assign ev[IDX_OPEN]  = (state_i == ST_TEST_OPEN)  & open_i;
  assign ev[IDX_RAIL]  = (state_i == ST_TEST_RAIL)  & rail_i;
  assign ev[IDX_OCP]   = ocp_i;
  assign ev[IDX_OTP]   = otp_i;

  assign ev_any_o = |ev;
  assign shown    = |(ev & ~mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ev_any_o)        trip_q <= 1'b1;
      else if (clr_rise_i) trip_q <= 1'b0;
      if (shown)           flag_q <= 1'b1;
      else if (clr_rise_i) flag_q <= 1'b0;
    end
  end

  assign trip_o = trip_q;
  assign flag_o = flag_q;

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_rise_i |=> flag_q);
  a_r8_masked_still_trips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_any_o |=> trip_q);
  a_r8_masked_hides_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q && ((ev & ~mask_i) == '0) |=> !flag_q);
endmodule

// File: rtl/load_diag_seq.sv
module load_diag_seq
  import diag_pkg::*;
#(
  parameter int STEP_CYC   = 2000,
  parameter int PERIOD_CYC = 60000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       diag_en_i,
  input  logic       diag_cont_i,
  input  logic       diag_clr_i,
  input  logic [4:0] ignore_mask_i,
  input  logic       rail_short_i,
  input  logic       out_short_i,
  input  logic       open_load_i,
  input  logic       over_cur_i,
  input  logic       over_temp_i,
  output logic       amp_en_o,
  output logic       fault_no,
  output logic       diag_busy_o,
  output logic       pwrup_hold_o
);
  logic en_q, cont_q, en_rise, clr_rise, pup, ev_any, trip, flag;
  logic [NUM_TESTS-1:0] mask_q;
  diag_state_e state;

  diag_cfg_sync u_cfg (
    .clk_i, .rst_ni,
    .freeze_i   (pup),
    .en_i       (diag_en_i),
    .cont_i     (diag_cont_i),
    .clr_i      (diag_clr_i),
    .mask_i     (ignore_mask_i),
    .en_o       (en_q),
    .cont_o     (cont_q),
    .mask_o     (mask_q),
    .en_rise_o  (en_rise),
    .clr_rise_o (clr_rise)
  );

  diag_fsm #(.STEP_CYC(STEP_CYC), .PERIOD_CYC(PERIOD_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .en_i       (en_q),
    .cont_i     (cont_q),
    .en_rise_i  (en_rise),
    .clr_rise_i (clr_rise),
    .abort_i    (diag_clr_i),
    .trip_ev_i  (ev_any),
    .state_o    (state),
    .pup_o      (pup),
    .busy_o     (diag_busy_o)
  );

  diag_fault_latch u_latch (
    .clk_i, .rst_ni,
    .state_i    (state),
    .rail_i     (rail_short_i),
    .short_i    (out_short_i),
    .open_i     (open_load_i),
    .ocp_i      (over_cur_i),
    .otp_i      (over_temp_i),
    .mask_i     (mask_q),
    .clr_rise_i (clr_rise),
    .ev_any_o   (ev_any),
    .trip_o     (trip),
    .flag_o     (flag)
  );

  assign amp_en_o     = ~pup & ~trip;
  assign fault_no     = ~flag;
  assign pwrup_hold_o = pup;

  a_r6_fault_pin_means_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_no |-> !amp_en_o);
  a_r1_hold_means_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrup_hold_o |-> !amp_en_o);
  a_r10_protect_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_cur_i || over_temp_i |=> !amp_en_o);
  a_r11_no_busy_when_tripped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip |-> !diag_busy_o);
endmodule

// File: tb/load_diag_seq_tb.sv
`timescale 1ns/1ps
module load_diag_seq_tb;
  localparam int STEP   = 4;
  localparam int PERIOD = 20;
  // model state codes (bench's own)
  localparam int M_IDLE = 0, M_HOLD = 1, M_RAIL = 2, M_SHORT = 3, M_OPEN = 4,
                 M_WAIT = 5, M_FLT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, cont = 0, drst = 0;
  logic [4:0] mask = '0;
  logic rail = 0, sh = 0, op = 0, ocp = 0, otp = 0;
  logic amp, fault_n, busy, hold;

  int compared = 0, mismatched = 0;
  string phase = "R1 power-up check";
  bit done = 0;

  always #2.5 clk = ~clk;

  load_diag_seq #(.STEP_CYC(STEP), .PERIOD_CYC(PERIOD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .diag_en_i(en), .diag_cont_i(cont),
    .diag_clr_i(drst), .ignore_mask_i(mask), .rail_short_i(rail),
    .out_short_i(sh), .open_load_i(op), .over_cur_i(ocp), .over_temp_i(otp),
    .amp_en_o(amp), .fault_no(fault_n), .diag_busy_o(busy), .pwrup_hold_o(hold)
  );

  // behavioural reference
  int ms, mc; bit mp, mt, mf, cen, ccont, crst, pen, prst;
  bit [4:0] cmask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = M_HOLD; mc = 0; mp = 1; mt = 0; mf = 0;
      cen = 0; ccont = 0; crst = 0; cmask = 0; pen = 0; prst = 0;
    end else begin
      bit er, rr, nt, nf, np, last;
      int ns, nc;
      bit [4:0] ev;
      er = cen && !pen;
      rr = crst && !prst;
      ev = 0;
      if (ms == M_SHORT && sh)  ev[0] = 1;
      if (ms == M_OPEN  && op)  ev[1] = 1;
      if (ms == M_RAIL  && rail) ev[2] = 1;
      ev[3] = ocp; ev[4] = otp;
      nt = mt; nf = mf;
      if (rr) begin nt = 0; nf = 0; end
      if (ev != 0) nt = 1;
      if ((ev & ~cmask) != 0) nf = 1;
      ns = ms; np = mp; last = (mc == STEP - 1);
      if (ev != 0) begin ns = M_FLT; np = 0; end
      else if (mp && drst) begin ns = M_IDLE; np = 0; end
      else if (rr) ns = M_IDLE;
      else begin
        case (ms)
          M_IDLE:  if (er) ns = M_RAIL;
          M_HOLD:  if (last) ns = M_RAIL;
          M_RAIL:  if (last) ns = M_SHORT;
          M_SHORT: if (last) ns = M_OPEN;
          M_OPEN:  if (last) begin
                     if (mp) begin ns = M_IDLE; np = 0; end
                     else if (ccont && cen) ns = M_WAIT;
                     else ns = M_IDLE;
                   end
          M_WAIT:  if (!ccont || !cen) ns = M_IDLE;
                   else if (mc == PERIOD - 1) ns = M_RAIL;
          default: ;
        endcase
      end
      nc = (ns != ms) ? 0 : mc + 1;
      pen = cen; prst = crst;
      if (!mp) begin cen = en; ccont = cont; crst = drst; cmask = mask; end
      ms = ns; mc = nc; mp = np; mt = nt; mf = nf;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_amp, e_fn, e_busy, e_hold;
      e_amp = !mp && !mt;
      e_fn = !mf;
      e_busy = (ms == M_RAIL) || (ms == M_SHORT) || (ms == M_OPEN);
      e_hold = mp;
      compared++;
      if ({amp, fault_n, busy, hold} !== {e_amp, e_fn, e_busy, e_hold}) begin
        mismatched++;
        $display("FAIL %s: amp/fault_n/busy/hold got %b%b%b%b expected %b%b%b%b at %0t",
                 phase, amp, fault_n, busy, hold, e_amp, e_fn, e_busy, e_hold, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_toggle();
    drst = 1; tick(3); drst = 0; tick(3);
  endtask

  task automatic en_pulse();
    en = 0; tick(2); en = 1;
  endtask

  initial begin
    tick(3); rst_n = 1;
    phase = "R1 power-up check"; tick(2);
    phase = "R2 buffered enable"; en = 1; tick(36);
    phase = "R4 one-shot edge"; tick(10); en = 0; tick(3); en = 1; tick(6);
    en = 0; tick(1); en = 1; tick(20);
    phase = "R9 load flags outside window"; rail = 1; sh = 1; op = 1; tick(10);
    rail = 0; sh = 0; op = 0;
    phase = "R6 latched fault"; en = 0; tick(2); sh = 1; en = 1; tick(10); sh = 0; tick(10);
    phase = "R7 clear edge"; clear_toggle();
    phase = "R8 masked rail short"; mask = 5'b00100; rail = 1; en_pulse(); tick(10);
    rail = 0; tick(3); clear_toggle(); mask = 0; tick(2);
    phase = "R10 protection always on"; ocp = 1; tick(1); ocp = 0; tick(4); clear_toggle();
    mask = 5'b10000; tick(2); otp = 1; tick(2); otp = 0; tick(3); clear_toggle();
    mask = 0; tick(2);
    phase = "R11 busy window"; en_pulse(); tick(16);
    phase = "R5 repeating runs"; cont = 1; en_pulse(); tick(80); cont = 0; tick(30);
    phase = "R12 repeat stops on fault"; cont = 1; en_pulse(); tick(40); op = 1; tick(40);
    op = 0; clear_toggle();
    phase = "R12 repeat stops on clear"; en_pulse(); tick(40); drst = 1; tick(5); drst = 0;
    tick(30); cont = 0;
    phase = "R3 power-up abort"; rst_n = 0; tick(2); rst_n = 1; tick(5);
    drst = 1; tick(3); drst = 0; tick(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule